// File: doc/BRIEF.md
# DMA Page Address Generator

This block sits beside a pair of cascaded DMA controllers that together provide eight channel numbers. Each controller emits only a 16-bit address. The block holds one 8-bit page register for each channel that has its own page, plus one for memory refresh. When a channel is active, it merges that channel's page with the controller's 16-bit address to form a 24-bit system address and a byte-high-enable. Software loads and reads back the page registers through simple I/O write and read strobes in a sixteen-port window.

Channels 0 to 3 move bytes. For these, the page sits directly above the 16-bit controller address. Channels 5 to 7 move 16-bit words. For these, the controller address is shifted up one bit, the page supplies only the seven bits above it, and the lowest address bit is always zero. In neither scheme does an increment of the controller address reach the page. A transfer therefore wraps inside its 64 KB block (byte channels) or its 128 KB block (word channels). Channel 4 links the first controller into the second. It has no page, and the block drives no address for it.

Top module: `dma_page_addr`

## Requirements
- R1: The registers decode at I/O addresses 0x87 (channel 0), 0x83 (channel 1), 0x81 (channel 2), 0x82 (channel 3), 0x8B (channel 5), 0x89 (channel 6), 0x8A (channel 7) and 0x8F (refresh). A write with `io_wr` high at one of these addresses updates that register on the clock edge.
- R2: While `io_rd` is high at a decoded address, `io_rdata` shows that register's current value, combinationally. Otherwise `io_rdata` is 0.
- R3: A write to any address in the window that does not decode (0x80, 0x84, 0x85, 0x86, 0x88, 0x8C, 0x8D, 0x8E), or to any address outside the 0x80 to 0x8F window, changes no register. A read of such an address returns 0.
- R4: When `dma_act` is high and `dma_ch` (binary channel number) is 0 to 3, `sys_addr[23:16]` equals that channel's page and `sys_addr[15:0]` equals `dma_addr`.
- R5: On channels 0 to 3, `bhe` is the inverse of `sys_addr[0]`.
- R6: On channels 5 to 7, `sys_addr[23:17]` equals page bits 7..1, `sys_addr[16:1]` equals `dma_addr`, and page bit 0 has no effect on the address.
- R7: On channels 5 to 7, `sys_addr[0]` and `bhe` are both 0.
- R8: With `dma_addr` at 0xFFFF, the page bits of `sys_addr` still equal the stored page: there is no carry into the page.
- R9: When `dma_act` is low, or `dma_ch` is 4, `addr_oe` is 0, `sys_addr` is 0 and `bhe` is 0. Otherwise `addr_oe` is 1.
- R10: The refresh register is readable and writable like the others, and its value never appears on `sys_addr` for any channel.
- R11: After reset, every page register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not a decoded read |
| dma_act | input | 1 | A DMA channel owns the bus |
| dma_ch | input | 3 | Active channel number, binary |
| dma_addr | input | 16 | Address from the DMA controller |
| sys_addr | output | 24 | System address A23..A0 |
| bhe | output | 1 | Byte-high-enable |
| addr_oe | output | 1 | Address outputs valid |

## Verification
The hardest case to reach is a word channel whose page has bit 0 set, driven at `dma_addr` 0xFFFF. Only this combination shows both that the odd page bit is dropped and that no carry leaks into the page. The bench writes an odd page to every word channel in directed steps. Its random loop then biases `dma_addr` towards the 0x0000 and 0xFFFF extremes while pages keep receiving random odd and even values. The refresh register is written between channel checks, so that its value would show up if it leaked onto the address.

// File: rtl/dma_page_addr.sv
module dma_page_addr #(
  parameter int IOA_W = 8,
  parameter int CA_W  = 16,
  parameter int PG_W  = 8,
  parameter logic [IOA_W-1:0] IO_BASE = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [IOA_W-1:0]      io_addr,
  input  logic [PG_W-1:0]       io_wdata,
  output logic [PG_W-1:0]       io_rdata,
  input  logic                  dma_act,
  input  logic [2:0]            dma_ch,
  input  logic [CA_W-1:0]       dma_addr,
  output logic [CA_W+PG_W-1:0]  sys_addr,
  output logic                  bhe,
  output logic                  addr_oe
);
  localparam int SA_W  = CA_W + PG_W;
  localparam int NSLOT = 8;

  // slot 4 holds the refresh page; channel 4 has none
  function automatic logic [3:0] slot_of(input logic [3:0] lo);
    case (lo)
      4'h7: slot_of = 4'b1_000;
      4'h3: slot_of = 4'b1_001;
      4'h1: slot_of = 4'b1_010;
      4'h2: slot_of = 4'b1_011;
      4'hF: slot_of = 4'b1_100;
      4'hB: slot_of = 4'b1_101;
      4'h9: slot_of = 4'b1_110;
      4'hA: slot_of = 4'b1_111;
      default: slot_of = 4'b0_000;
    endcase
  endfunction

  logic [PG_W-1:0] page [NSLOT];
  logic [3:0]      sel;
  logic            hit;

  assign sel = slot_of(io_addr[3:0]);
  assign hit = (io_addr[IOA_W-1:4] == IO_BASE[IOA_W-1:4]) && sel[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) page[i] <= '0;
    end else if (io_wr && hit) begin
      page[sel[2:0]] <= io_wdata;
    end
  end

  assign io_rdata = (io_rd && hit) ? page[sel[2:0]] : '0;

  logic            drive, word;
  logic [PG_W-1:0] pg;
  logic [SA_W-1:0] byte_addr, word_addr;

  assign drive     = dma_act && (dma_ch != 3'd4);
  assign word      = dma_ch[2];
  assign pg        = page[dma_ch];
  assign byte_addr = {pg, dma_addr};
  assign word_addr = {pg[PG_W-1:1], dma_addr, 1'b0};

  assign addr_oe  = drive;
  assign sys_addr = !drive ? '0 : (word ? word_addr : byte_addr);
  assign bhe      = drive && !word && !dma_addr[0];
endmodule

module dma_page_addr_chk #(
  parameter int IOA_W = 8,
  parameter int CA_W  = 16,
  parameter int PG_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 io_wr,
  input logic                 io_rd,
  input logic [IOA_W-1:0]     io_addr,
  input logic [PG_W-1:0]      io_wdata,
  input logic [PG_W-1:0]      io_rdata,
  input logic                 dma_act,
  input logic [2:0]           dma_ch,
  input logic [CA_W-1:0]      dma_addr,
  input logic [CA_W+PG_W-1:0] sys_addr,
  input logic                 bhe,
  input logic                 addr_oe
);
  function automatic logic is_reg(input logic [IOA_W-1:0] a);
    logic [3:0] lo;
    lo = a[3:0];
    is_reg = (a[IOA_W-1:4] == 'h8) &&
             (lo == 4'h7 || lo == 4'h3 || lo == 4'h1 || lo == 4'h2 ||
              lo == 4'hF || lo == 4'hB || lo == 4'h9 || lo == 4'hA);
  endfunction

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_act |-> (!addr_oe && sys_addr == '0 && !bhe));
  // R4
  byte_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && !dma_ch[2]) |-> sys_addr[CA_W-1:0] == dma_addr);
  // R5
  byte_bhe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && !dma_ch[2]) |-> bhe == !sys_addr[0]);
  // R6
  word_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && dma_ch[2]) |-> sys_addr[CA_W:1] == dma_addr);
  // R7
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && dma_ch[2]) |-> (!sys_addr[0] && !bhe));
  // R3
  unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !is_reg(io_addr)) |-> io_rdata == '0);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && $past(io_wr) && $past(rst_n) && is_reg(io_addr) && io_addr == $past(io_addr))
      |-> io_rdata == $past(io_wdata));
endmodule

bind dma_page_addr dma_page_addr_chk #(.IOA_W(IOA_W), .CA_W(CA_W), .PG_W(PG_W)) u_chk (.*);

// File: tb/dma_page_addr_tb.sv
module dma_page_addr_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        dma_act = 0;
  logic [2:0]  dma_ch = 0;
  logic [15:0] dma_addr = 0;
  logic [23:0] sys_addr;
  logic        bhe, addr_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl [8];

  always #2 clk = ~clk;

  dma_page_addr u_dut (.*);

  function automatic int slot(input logic [7:0] a);
    case (a)
      8'h87: return 0; 8'h83: return 1; 8'h81: return 2; 8'h82: return 3;
      8'h8F: return 4; 8'h8B: return 5; 8'h89: return 6; 8'h8A: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [25:0] expect_bus(input logic act, input logic [2:0] ch,
                                             input logic [15:0] a);
    logic [7:0] p;
    if (!act || ch == 3'd4) return 26'd0;
    p = mdl[ch];
    if (ch < 3'd4) return {1'b1, ~a[0], p, a};
    return {1'b1, 1'b0, p[7:1], a, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
    if (slot(a) >= 0) mdl[slot(a)] = d;
  endtask

  task automatic io_read_check(input string req, input logic [7:0] a);
    logic [7:0] e;
    @(negedge clk);
    io_rd = 1; io_addr = a;
    #1;
    e = (slot(a) >= 0) ? mdl[slot(a)] : 8'h00;
    check(req, {24'd0, io_rdata}, {24'd0, e});
    io_rd = 0;
  endtask

  task automatic dma_check(input string req, input logic act, input logic [2:0] ch,
                           input logic [15:0] a);
    @(negedge clk);
    dma_act = act; dma_ch = ch; dma_addr = a;
    #1;
    check(req, {6'd0, addr_oe, bhe, sys_addr}, {6'd0, expect_bus(act, ch, a)});
    dma_act = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    for (int i = 0; i < 16; i++) io_read_check("R11", 8'h80 + 8'(i));
    dma_check("R9", 1'b0, 3'd0, 16'h1234);

    // R1 decode map, distinct values per register
    io_write(8'h87, 8'h10); io_write(8'h83, 8'h21); io_write(8'h81, 8'h32);
    io_write(8'h82, 8'h43); io_write(8'h8B, 8'h55); io_write(8'h89, 8'h67);
    io_write(8'h8A, 8'h79); io_write(8'h8F, 8'hC3);
    for (int i = 0; i < 16; i++) io_read_check("R1", 8'h80 + 8'(i));

    // R3 unused addresses ignored
    io_write(8'h80, 8'hAA); io_write(8'h84, 8'hAB); io_write(8'h8E, 8'hAC);
    io_write(8'h07, 8'hAD); io_write(8'h97, 8'hAE);
    for (int i = 0; i < 16; i++) io_read_check("R3", 8'h80 + 8'(i));
    io_read_check("R3", 8'h07);

    // R4 R5 byte channels
    dma_check("R4", 1'b1, 3'd0, 16'h1234);
    dma_check("R5", 1'b1, 3'd3, 16'hABCD);
    // R6 R7 word channels with odd page
    dma_check("R6", 1'b1, 3'd5, 16'h1234);
    dma_check("R7", 1'b1, 3'd7, 16'h8001);
    // R8 no carry at the top of a page
    io_write(8'h87, 8'h12); io_write(8'h8A, 8'hFF);
    dma_check("R8", 1'b1, 3'd0, 16'hFFFF);
    dma_check("R8", 1'b1, 3'd7, 16'hFFFF);
    check("R8", {8'd0, sys_addr}, 32'h00FF_FFFE);
    // R9 channel 4 and idle
    dma_check("R9", 1'b1, 3'd4, 16'h5555);
    dma_check("R9", 1'b0, 3'd6, 16'hFFFF);
    // R10 refresh value never reaches the bus
    io_write(8'h8F, 8'hEE);
    for (int c = 0; c < 8; c++) dma_check("R10", 1'b1, 3'(c), 16'h0F0F);
    io_read_check("R10", 8'h8F);

    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] a;
      logic [15:0] da;
      op = int'($urandom_range(0, 2));
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h80 + 8'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: da = 16'h0000;
        1: da = 16'hFFFF;
        default: da = 16'($urandom);
      endcase
      if (op == 0) io_write(a, 8'($urandom));
      else if (op == 1) io_read_check("R2", a);
      else dma_check(((n % 2) == 0) ? "R4" : "R6", $urandom_range(0, 5) != 0,
                     3'($urandom_range(0, 7)), da);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule